// File: doc/BRIEF.md
# Bus Comparator Debug Trigger

This block sits beside a processor bus and watches every access. Four address comparators, numbered 0 to 3, each look at one of two selectable bus masters. Comparators 0 and 2 also compare the data value through a per-bit mask. Comparators 1 and 3 compare the address only. Comparators 0 and 2 lead a pair. When a leader is put into a range mode, its own reference becomes the lower bound and its partner's reference (1 or 3) the upper bound. The partner then stops matching on its own.

A match can raise a force-type breakpoint request, which appears in the cycle after the access. It can instead raise a tag-type request. A tag attaches to an instruction fetch and is reported only when the pipeline signals that the tagged instruction executes. Any match also serves as the trigger for a 64-entry, 64-bit circular trace buffer. The buffer records either change-of-flow accesses only or every access. A small state machine runs the capture with four states: TRC_IDLE, TRC_ARMED, TRC_POST and TRC_DONE. Its transitions are:

- ARM (any state to TRC_ARMED, on a trace-control write with the arm bit set)
- DISARM (any state to TRC_IDLE, on a trace-control write with the arm bit clear)
- TRIG (TRC_ARMED to TRC_POST, on a match when the post length is non-zero)
- TRIG_DONE (TRC_ARMED to TRC_DONE, on a match when the post length is zero)
- FILL (TRC_POST to TRC_DONE, once the post length of entries has been written after the trigger)

In TRC_DONE the buffer is frozen. It is read through an index port.

Top module: `bus_watch_trigger`

## Requirements
- R1: After reset, brk_force, brk_tag, trace_done and trace_wrapped are 0, trace_ptr is 0 and the machine is in TRC_IDLE.
- R2: A comparator matches only when bus_valid is 1, its enable bit (control bit 0) is set and bus_master equals its master-select bit (control bit 1). In exact mode (control bits 3:2 = 0), comparators 1 and 3 match when bus_addr equals their reference.
- R3: Comparators 0 and 2 also require ((bus_data XOR data_ref) AND data_mask) == 0. The configuration word holds the mask in bits 31:16 and the reference in bits 15:0. A mask bit of 0 makes that data bit a don't-care.
- R4: Inside mode (leader control bits 3:2 = 1) matches when the leader's reference <= bus_addr <= the partner's reference. Both bounds are inclusive.
- R5: Outside mode (bits 3:2 = 2) matches when bus_addr is below the lower bound or above the upper bound. While its leader is in either range mode, comparator 1 or 3 never matches on its own.
- R6: A match with action force (control bits 5:4 = 1) sets brk_force for exactly the cycle after the access.
- R7: A match with action tag (bits 5:4 = 2) on an access with bus_fetch set marks a pending tag. brk_tag is 1 in the cycle after an instr_exec pulse while a tag is pending. pipe_flush clears the pending tag. A tag match on a non-fetch access marks nothing.
- R8: Trace-control bit 1 = 0 records only accesses with bus_cof set, as {2'b01, master, 22'b0, addr, 16'b0}. Bit 1 = 1 records every access, as {2'b10, master, 22'b0, addr, data}. Bits are listed MSB first.
- R9: trace_ptr advances once per recorded entry and wraps from 63 to 0. trace_wrapped is set at the wrap and stays set until the capture is re-armed.
- R10: Any enabled match while in TRC_ARMED is the trigger. After the trigger, capture stops once the post length has been written. The post length is held in trace-control bits 13:8, and a post length of 0 stops capture at the trigger entry itself. In TRC_DONE nothing is written and trace_done is 1. A re-arm clears trace_ptr, trace_wrapped and trace_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register select: 0-3 comparator reference, 4-7 comparator control, 8/9 data of comparator 0/2, 10 trace control |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_master | input | 1 | Which of the two masters drives the access |
| bus_addr | input | 23 | Access address |
| bus_data | input | 16 | Access data |
| bus_cof | input | 1 | Access is a change-of-flow target |
| bus_fetch | input | 1 | Access is an instruction fetch |
| instr_exec | input | 1 | The oldest tagged instruction executes |
| pipe_flush | input | 1 | Pipeline flush; drops a pending tag |
| rd_idx | input | 6 | Trace buffer read index |
| rd_data | output | 64 | Trace entry at rd_idx |
| trace_ptr | output | 6 | Next trace write position |
| trace_wrapped | output | 1 | Buffer has been filled at least once |
| trace_done | output | 1 | Capture has stopped |
| brk_force | output | 1 | Force breakpoint request |
| brk_tag | output | 1 | Tag breakpoint request |

## Verification
A single bus access can be the trace trigger, a recorded entry and a force breakpoint all at once. The post-trigger test sets comparator 1 to force action while capture is armed in every-access mode, so that one access lands on it. The bench then requires three things from that one cycle: brk_force rises on the next cycle, the pointer advances past the triggering entry, and the machine counts exactly the post length of later entries before trace_done rises. The tag path is judged the same way: a pending tag and a flush are placed against a later instr_exec, and the bench requires silence on brk_tag.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
    typedef enum logic [1:0] {
        CMP_EXACT   = 2'd0,
        CMP_INSIDE  = 2'd1,
        CMP_OUTSIDE = 2'd2,
        CMP_RSVD    = 2'd3
    } cmp_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FORCE = 2'd1,
        ACT_TAG   = 2'd2,
        ACT_RSVD  = 2'd3
    } cmp_act_e;

    typedef enum logic [1:0] {
        TRC_IDLE  = 2'd0,
        TRC_ARMED = 2'd1,
        TRC_POST  = 2'd2,
        TRC_DONE  = 2'd3
    } trc_state_e;

    localparam int NUM_CMP     = 4;
    localparam logic [3:0] CFG_DATA0 = 4'd8;
    localparam logic [3:0] CFG_DATA2 = 4'd9;
    localparam logic [3:0] CFG_TRACE = 4'd10;
endpackage

// File: rtl/bwt_comparator.sv
module bwt_comparator
    import bwt_pkg::*;
#(
    parameter int  ADDR_W = 23,
    parameter int  DATA_W = 16,
    parameter bit  LEADER = 1'b1
) (
    input  logic              en,
    input  logic              master_sel,
    input  cmp_mode_e         mode,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] data_mask,
    input  logic              bus_valid,
    input  logic              bus_master,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              hit
);
    logic addr_eq, in_range, addr_ok, data_ok;

    always_comb begin
        addr_eq  = (bus_addr == ref_addr);
        in_range = (bus_addr >= ref_addr) && (bus_addr <= hi_addr);
        if (LEADER) begin
            unique case (mode)
                CMP_INSIDE:  addr_ok = in_range;
                CMP_OUTSIDE: addr_ok = !in_range;
                default:     addr_ok = addr_eq;
            endcase
            data_ok = (((bus_data ^ ref_data) & data_mask) == '0);
        end else begin
            addr_ok = addr_eq;
            data_ok = 1'b1;
        end
        hit = en && bus_valid && (bus_master == master_sel) && addr_ok && data_ok;
    end
endmodule

// File: rtl/bwt_trace_buf.sv
module bwt_trace_buf #(
    parameter int DEPTH   = 64,
    parameter int ENTRY_W = 64,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic               wrapped
);
    logic [ENTRY_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (clr) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (we) begin
            if (wr_ptr == PTR_W'(DEPTH - 1)) begin
                wr_ptr  <= '0;
                wrapped <= 1'b1;
            end else begin
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_idx];

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && wr_ptr == PTR_W'(DEPTH - 1)) |=> (wr_ptr == '0 && wrapped)); // R9
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !clr) |=> wrapped); // R9
endmodule

// File: rtl/bus_watch_trigger.sv
module bus_watch_trigger
    import bwt_pkg::*;
#(
    parameter int ADDR_W    = 23,
    parameter int DATA_W    = 16,
    parameter int TRC_DEPTH = 64,
    parameter int ENTRY_W   = 64,
    localparam int PTR_W    = $clog2(TRC_DEPTH),
    localparam int PAD_W    = ENTRY_W - 3 - ADDR_W - DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_addr,
    input  logic [31:0]        cfg_wdata,
    input  logic               bus_valid,
    input  logic               bus_master,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               bus_cof,
    input  logic               bus_fetch,
    input  logic               instr_exec,
    input  logic               pipe_flush,
    input  logic [PTR_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [PTR_W-1:0]   trace_ptr,
    output logic               trace_wrapped,
    output logic               trace_done,
    output logic               brk_force,
    output logic               brk_tag
);
    logic [ADDR_W-1:0] cmp_ref  [NUM_CMP];
    logic              cmp_en   [NUM_CMP];
    logic              cmp_msel [NUM_CMP];
    cmp_mode_e         cmp_mode [NUM_CMP];
    cmp_act_e          cmp_act  [NUM_CMP];
    logic [DATA_W-1:0] dat_ref  [NUM_CMP/2];
    logic [DATA_W-1:0] dat_mask [NUM_CMP/2];
    logic              trc_all;
    logic [PTR_W-1:0]  post_len;
    logic [PTR_W-1:0]  post_cnt;
    trc_state_e        state, nxt;
    logic              tag_pend;

    logic [NUM_CMP-1:0] raw_hit, hit, is_force, is_tag;
    logic arm_wr, trig, wr_qual, trc_we;
    logic [ENTRY_W-1:0] entry;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CMP; i++) begin
                cmp_ref[i]  <= '0;
                cmp_en[i]   <= 1'b0;
                cmp_msel[i] <= 1'b0;
                cmp_mode[i] <= CMP_EXACT;
                cmp_act[i]  <= ACT_NONE;
            end
            for (int j = 0; j < NUM_CMP/2; j++) begin
                dat_ref[j]  <= '0;
                dat_mask[j] <= '0;
            end
            trc_all  <= 1'b0;
            post_len <= '0;
        end else if (cfg_we) begin
            if (cfg_addr < 4'd4) begin
                cmp_ref[cfg_addr[1:0]] <= cfg_wdata[ADDR_W-1:0];
            end else if (cfg_addr < 4'd8) begin
                cmp_en[cfg_addr[1:0]]   <= cfg_wdata[0];
                cmp_msel[cfg_addr[1:0]] <= cfg_wdata[1];
                cmp_mode[cfg_addr[1:0]] <= cmp_mode_e'(cfg_wdata[3:2]);
                cmp_act[cfg_addr[1:0]]  <= cmp_act_e'(cfg_wdata[5:4]);
            end else if (cfg_addr == CFG_DATA0 || cfg_addr == CFG_DATA2) begin
                dat_ref[cfg_addr[0]]  <= cfg_wdata[DATA_W-1:0];
                dat_mask[cfg_addr[0]] <= cfg_wdata[16 +: DATA_W];
            end else if (cfg_addr == CFG_TRACE) begin
                trc_all  <= cfg_wdata[1];
                post_len <= cfg_wdata[8 +: PTR_W];
            end
        end
    end

    // comparators: even index leads a pair and carries the data compare
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        bwt_comparator #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .LEADER ((g % 2) == 0)
        ) u_cmp (
            .en         (cmp_en[g]),
            .master_sel (cmp_msel[g]),
            .mode       (cmp_mode[g]),
            .ref_addr   (cmp_ref[g]),
            .hi_addr    (cmp_ref[g | 1]),
            .ref_data   (dat_ref[g / 2]),
            .data_mask  (dat_mask[g / 2]),
            .bus_valid  (bus_valid),
            .bus_master (bus_master),
            .bus_addr   (bus_addr),
            .bus_data   (bus_data),
            .hit        (raw_hit[g])
        );
        if ((g % 2) == 1) begin : g_follow
            assign hit[g] = raw_hit[g] &&
                !(cmp_mode[g-1] == CMP_INSIDE || cmp_mode[g-1] == CMP_OUTSIDE);
        end else begin : g_lead
            assign hit[g] = raw_hit[g];
        end
        assign is_force[g] = (cmp_act[g] == ACT_FORCE);
        assign is_tag[g]   = (cmp_act[g] == ACT_TAG);
    end

    assign trig    = |hit;
    assign arm_wr  = cfg_we && (cfg_addr == CFG_TRACE);
    assign wr_qual = bus_valid && (trc_all || bus_cof);
    assign entry   = {(trc_all ? 2'b10 : 2'b01), bus_master, {PAD_W{1'b0}},
                      bus_addr, (trc_all ? bus_data : {DATA_W{1'b0}})};

    // breakpoint requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_force <= 1'b0;
            brk_tag   <= 1'b0;
            tag_pend  <= 1'b0;
        end else begin
            brk_force <= |(hit & is_force);
            brk_tag   <= instr_exec && tag_pend && !pipe_flush;
            if (pipe_flush || instr_exec)
                tag_pend <= 1'b0;
            else if (bus_fetch && |(hit & is_tag))
                tag_pend <= 1'b1;
        end
    end

    // trace state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TRC_IDLE;
            post_cnt <= '0;
        end else if (arm_wr) begin
            state    <= cfg_wdata[0] ? TRC_ARMED : TRC_IDLE;
            post_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == TRC_POST && trc_we)
                post_cnt <= post_cnt + 1'b1;
        end
    end

    // trace next state and outputs
    always_comb begin
        nxt = state;
        unique case (state)
            TRC_IDLE:  nxt = TRC_IDLE;
            TRC_ARMED: if (trig) nxt = (post_len == '0) ? TRC_DONE : TRC_POST;
            TRC_POST:  if (wr_qual && PTR_W'(post_cnt + 1'b1) == post_len) nxt = TRC_DONE;
            TRC_DONE:  nxt = TRC_DONE;
        endcase
    end

    always_comb begin
        trc_we     = (state == TRC_ARMED || state == TRC_POST) && wr_qual && !arm_wr;
        trace_done = (state == TRC_DONE);
    end

    bwt_trace_buf #(
        .DEPTH   (TRC_DEPTH),
        .ENTRY_W (ENTRY_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (arm_wr && cfg_wdata[0]),
        .we      (trc_we),
        .wdata   (entry),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_ptr  (trace_ptr),
        .wrapped (trace_wrapped)
    );

    AST_FORCE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        brk_force |-> $past(bus_valid)); // R6
    AST_TAG_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        brk_tag |-> $past(instr_exec)); // R7
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRC_DONE && !arm_wr) |=> $stable(trace_ptr)); // R10
    AST_IDLE_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TRC_IDLE && !arm_wr) |=> state == TRC_IDLE); // R10
endmodule

// File: tb/bus_watch_trigger_test.sv
module bus_watch_trigger_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0, bus_master = 1'b0;
    logic [22:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_cof = 1'b0, bus_fetch = 1'b0, instr_exec = 1'b0, pipe_flush = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic [5:0]  trace_ptr;
    logic        trace_wrapped, trace_done, brk_force, brk_tag;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_watch_trigger uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_master(bus_master),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_cof(bus_cof),
        .bus_fetch(bus_fetch), .instr_exec(instr_exec), .pipe_flush(pipe_flush),
        .rd_idx(rd_idx), .rd_data(rd_data), .trace_ptr(trace_ptr),
        .trace_wrapped(trace_wrapped), .trace_done(trace_done),
        .brk_force(brk_force), .brk_tag(brk_tag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic acc(input logic v, input logic m, input logic [22:0] a, input logic [15:0] d,
                       input logic cof, input logic fetch, input logic ex, input logic fl);
        @(negedge clk);
        bus_valid = v; bus_master = m; bus_addr = a; bus_data = d;
        bus_cof = cof; bus_fetch = fetch; instr_exec = ex; pipe_flush = fl;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_cof = 1'b0; bus_fetch = 1'b0;
        instr_exec = 1'b0; pipe_flush = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input logic en, input logic m,
                                         input logic [1:0] mode, input logic [1:0] act);
        return {26'b0, act, mode, m, en};
    endfunction

    function automatic logic [63:0] ent(input logic [1:0] kind, input logic m,
                                        input logic [22:0] a, input logic [15:0] d);
        return {kind, m, 22'b0, a, d};
    endfunction

    task automatic clear_cmp();
        for (int i = 4; i < 8; i++) cfg_wr(4'(i), 32'h0);
        cfg_wr(4'd8, 32'h0);
        cfg_wr(4'd9, 32'h0);
    endtask

    task automatic read_entry(input logic [5:0] idx, output logic [63:0] val);
        rd_idx = idx; #1; val = rd_data;
    endtask

    task automatic t_reset();
        check("R1 brk_force", brk_force, 0);
        check("R1 brk_tag", brk_tag, 0);
        check("R1 trace_ptr", trace_ptr, 0);
        check("R1 trace_wrapped", trace_wrapped, 0);
        check("R1 trace_done", trace_done, 0);
    endtask

    task automatic t_exact();
        clear_cmp();
        cfg_wr(4'd1, 32'h12345);
        cfg_wr(4'd5, ctl(1, 0, 2'd0, 2'd1));
        acc(1, 0, 23'h12345, 16'h0, 0, 0, 0, 0);
        check("R2 exact hit", brk_force, 1);
        acc(1, 1, 23'h12345, 16'h0, 0, 0, 0, 0);
        check("R2 wrong master", brk_force, 0);
        acc(1, 0, 23'h12346, 16'h0, 0, 0, 0, 0);
        check("R2 addr miss", brk_force, 0);
        acc(0, 0, 23'h12345, 16'h0, 0, 0, 0, 0);
        check("R2 no valid", brk_force, 0);
    endtask

    task automatic t_data();
        clear_cmp();
        cfg_wr(4'd0, 32'h100);
        cfg_wr(4'd8, 32'h00FF_00AB);
        cfg_wr(4'd4, ctl(1, 0, 2'd0, 2'd1));
        acc(1, 0, 23'h100, 16'h55AB, 0, 0, 0, 0);
        check("R3 masked high bits ignored", brk_force, 1);
        acc(1, 0, 23'h100, 16'h00AC, 0, 0, 0, 0);
        check("R3 data miss", brk_force, 0);
        acc(1, 0, 23'h101, 16'h00AB, 0, 0, 0, 0);
        check("R3 addr miss", brk_force, 0);
    endtask

    task automatic t_inside();
        clear_cmp();
        cfg_wr(4'd0, 32'h200);
        cfg_wr(4'd1, 32'h210);
        cfg_wr(4'd4, ctl(1, 0, 2'd1, 2'd1));
        acc(1, 0, 23'h200, 16'h0, 0, 0, 0, 0);
        check("R4 low bound", brk_force, 1);
        acc(1, 0, 23'h210, 16'h0, 0, 0, 0, 0);
        check("R4 high bound", brk_force, 1);
        acc(1, 0, 23'h211, 16'h0, 0, 0, 0, 0);
        check("R4 above", brk_force, 0);
        acc(1, 0, 23'h1FF, 16'h0, 0, 0, 0, 0);
        check("R4 below", brk_force, 0);
    endtask

    task automatic t_outside();
        cfg_wr(4'd4, ctl(1, 0, 2'd2, 2'd1));
        cfg_wr(4'd5, ctl(1, 0, 2'd0, 2'd1));
        acc(1, 0, 23'h210, 16'h0, 0, 0, 0, 0);
        check("R5 partner suppressed at bound", brk_force, 0);
        acc(1, 0, 23'h211, 16'h0, 0, 0, 0, 0);
        check("R5 above range", brk_force, 1);
        acc(1, 0, 23'h1FF, 16'h0, 0, 0, 0, 0);
        check("R5 below range", brk_force, 1);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 0, 0);
        check("R6 drops after one cycle", brk_force, 0);
    endtask

    task automatic t_tag();
        clear_cmp();
        cfg_wr(4'd3, 32'h4000);
        cfg_wr(4'd7, ctl(1, 0, 2'd0, 2'd2));
        acc(1, 0, 23'h4000, 16'h0, 0, 1, 0, 0);
        check("R7 no tag before exec", brk_tag, 0);
        check("R7 tag is not force", brk_force, 0);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 1, 0);
        check("R7 tag on exec", brk_tag, 1);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 0, 0);
        check("R7 tag one cycle", brk_tag, 0);
        acc(1, 0, 23'h4000, 16'h0, 0, 1, 0, 0);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 0, 1);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 1, 0);
        check("R7 flush cancels", brk_tag, 0);
        acc(1, 0, 23'h4000, 16'h0, 0, 0, 0, 0);
        acc(0, 0, 23'h0, 16'h0, 0, 0, 1, 0);
        check("R7 non-fetch untagged", brk_tag, 0);
    endtask

    task automatic t_modes();
        logic [63:0] v;
        clear_cmp();
        cfg_wr(4'd10, 32'h1);
        acc(1, 0, 23'h055, 16'h1234, 0, 0, 0, 0);
        check("R8 cof mode skips plain access", trace_ptr, 0);
        acc(1, 1, 23'h111, 16'h9999, 1, 0, 0, 0);
        check("R8 cof recorded", trace_ptr, 1);
        read_entry(6'd0, v);
        check("R8 cof entry", v, ent(2'b01, 1, 23'h111, 16'h0));
        cfg_wr(4'd10, 32'h3);
        check("R10 rearm clears ptr", trace_ptr, 0);
        acc(1, 1, 23'h222, 16'hBEEF, 0, 0, 0, 0);
        read_entry(6'd0, v);
        check("R8 every-access entry", v, ent(2'b10, 1, 23'h222, 16'hBEEF));
    endtask

    task automatic t_wrap();
        logic [63:0] v;
        cfg_wr(4'd10, 32'h3);
        for (int i = 0; i < 63; i++) acc(1, 0, 23'(i), 16'(i + 7), 0, 0, 0, 0);
        check("R9 ptr at 63", trace_ptr, 63);
        check("R9 not wrapped yet", trace_wrapped, 0);
        acc(1, 0, 23'd63, 16'd70, 0, 0, 0, 0);
        check("R9 ptr wraps", trace_ptr, 0);
        check("R9 wrapped set", trace_wrapped, 1);
        acc(1, 0, 23'd64, 16'd71, 0, 0, 0, 0);
        read_entry(6'd0, v);
        check("R9 oldest overwritten", v, ent(2'b10, 0, 23'd64, 16'd71));
        read_entry(6'd1, v);
        check("R9 next kept", v, ent(2'b10, 0, 23'd1, 16'd8));
        check("R9 wrapped sticky", trace_wrapped, 1);
    endtask

    task automatic t_post();
        logic [63:0] v;
        clear_cmp();
        cfg_wr(4'd1, 32'h500);
        cfg_wr(4'd5, ctl(1, 0, 2'd0, 2'd1));
        cfg_wr(4'd10, 32'h203);
        check("R10 rearm clears wrapped", trace_wrapped, 0);
        acc(1, 0, 23'h10, 16'h1, 0, 0, 0, 0);
        acc(1, 0, 23'h500, 16'h2, 0, 0, 0, 0);
        check("R6 force on trigger access", brk_force, 1);
        check("R10 trigger recorded", trace_ptr, 2);
        check("R10 not done at trigger", trace_done, 0);
        acc(1, 0, 23'h11, 16'h3, 0, 0, 0, 0);
        check("R10 post one", trace_done, 0);
        acc(1, 0, 23'h12, 16'h4, 0, 0, 0, 0);
        check("R10 done after post length", trace_done, 1);
        check("R10 ptr after post", trace_ptr, 4);
        acc(1, 0, 23'h13, 16'h5, 0, 0, 0, 0);
        check("R10 frozen", trace_ptr, 4);
        read_entry(6'd1, v);
        check("R10 trigger entry", v, ent(2'b10, 0, 23'h500, 16'h2));
        cfg_wr(4'd10, 32'h003);
        check("R10 rearm clears done", trace_done, 0);
        acc(1, 0, 23'h500, 16'h6, 0, 0, 0, 0);
        check("R10 zero post stops at trigger", trace_done, 1);
        check("R10 zero post ptr", trace_ptr, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_exact();
        t_data();
        t_inside();
        t_outside();
        t_tag();
        t_modes();
        t_wrap();
        t_post();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule